// File: doc/BRIEF.md
# Nonvolatile Memory Busy and Power Sequencer

This block sits between a CPU bus and an embedded nonvolatile array. The array has a program area and an emulated-EEPROM area. The block follows the write, erase, suspend and resume events that the array controller reports. While a write is modifying a region, bus reads of that region return the blank byte 0xFF, which the CPU treats as a no-op. While the EEPROM area is busy, writes to that area are dropped before they reach the array.

It also runs the array's low-power sequence:
- A wait-for-interrupt request goes to standby or to deep power-down, as a configuration bit selects.
- Halt and stop requests always go to deep power-down.
- Entry into either low-power state waits until no write is in flight.
- Leaving deep power-down starts a recovery window, during which bus accesses are stalled with a wait signal.
- After the recovery window comes a ready window, during which the EEPROM area still reports busy. The same ready window follows reset.

A single interrupt channel is switched between an external pin and a one-cycle end-of-write pulse. A status byte carries a sticky write-error flag and per-sector status bits. The sector map follows one of two array-size configurations.

The bus is combinational: the array answers reads in the same cycle. Address bit `ADDR_W-1` = 1 selects the EEPROM area, and 0 selects the program area. The window lengths are computed in clock cycles from `CLK_MHZ`, `RECOV_NS` and `READY_NS`. The recovery window is `RECOV_CYC` cycles and the ready window is `READY_CYC` cycles.

Write tracker states:
- `WR_IDLE`
- `WR_PROG`
- `WR_EE`
- `WR_SUSP`

Write tracker transitions:
- Start: from `WR_IDLE` to `WR_PROG` or to `WR_EE`.
- Finish: on done or fail, back to `WR_IDLE`.
- Suspend: from either busy state to `WR_SUSP`.
- Resume: from `WR_SUSP` back to the busy state that was suspended.

Power states:
- `PW_READY_WAIT`
- `PW_ACTIVE`
- `PW_ENTRY_PEND`
- `PW_STANDBY`
- `PW_POWERDOWN`
- `PW_RECOVER`

Power transitions:
- Reset enters `PW_READY_WAIT`.
- When the ready window expires, `PW_READY_WAIT` moves to `PW_ACTIVE`.
- A request in `PW_ACTIVE` moves to `PW_ENTRY_PEND`.
- `PW_ENTRY_PEND` moves to `PW_STANDBY` or `PW_POWERDOWN` once no write is active.
- A wake in `PW_STANDBY` returns to `PW_ACTIVE`.
- A wake in `PW_POWERDOWN` moves to `PW_RECOVER`.
- When the recovery window expires, `PW_RECOVER` moves to `PW_READY_WAIT`.

Top module: `nvm_busy_pwr_seq`

## Requirements
- R1: From reset until `READY_CYC` clock edges after `rst_n` rises, `ee_busy` is 1. During this time EEPROM-area reads return 0xFF and EEPROM-area writes do not reach `arr_wr`. Program-area reads are served.
- R2: `ee_busy` rises one edge after `ee_page_latch` is sampled. It also rises one edge after `chip_erase_start` is sampled with `cfg_ee_chip_mode`=1. When `chip_erase_start` is sampled with `cfg_ee_chip_mode`=0, the program area becomes busy instead and `ee_busy` stays 0.
- R3: A busy write ends one edge after `wr_done` or `wr_fail`. It also ends one edge after `erase_suspend`. One edge after `erase_resume`, the suspended area is busy again.
- R4: While `ee_busy`=1, an EEPROM-area read returns 0xFF with `arr_rd`=0. While `ee_busy`=1, an EEPROM-area write leaves `arr_wr`=0.
- R5: While a program-area write is active, program-area reads return 0xFF. EEPROM-area reads are still served at that time.
- R6: A low-power request made while a write is active causes no low-power output until the write has ended. Entry then happens on the second edge after the ending event.
- R7: With no write active, the low-power output rises two edges after the request. `req_wfi` with `cfg_wfi_deep`=0 sets `arr_standby`. `req_wfi` with `cfg_wfi_deep`=1 sets `arr_powerdown`, and `req_halt` always sets `arr_powerdown`. The two outputs are never both 1.
- R8: In standby, reads are served with `bus_wait`=0. One edge after `wake`, `arr_standby` falls.
- R9: In power-down, any bus access raises `bus_wait`. After `wake`, `bus_wait` stays high for `RECOV_CYC` cycles. `ee_busy` is then 1 for `READY_CYC` more cycles.
- R10: With `cfg_irq_eow`=0, `irq_out` equals `ext_irq`.
- R11: With `cfg_irq_eow`=1, `irq_out` is a one-cycle pulse on the edge that ends a write by `wr_done`. No pulse follows `wr_fail` or `erase_suspend`.
- R12: `status_reg[7]` is set one edge after `wr_fail` during a write. It is cleared only by `err_clr`, and a set in the same cycle wins over the clear.
- R13: `status_reg[6]` = `otp_stat` and `status_reg[5:4]` = `ee_sect_stat`. With `LARGE_ARRAY`=1, `status_reg[3]` is the OR of `pf_sect_stat[5:3]` and `status_reg[2:0]` = `pf_sect_stat[2:0]`. With `LARGE_ARRAY`=0, `status_reg[3:0]` = `pf_sect_stat[3:0]`.
- R14: Low-power requests outside `PW_ACTIVE` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| bus_rd | input | 1 | CPU read strobe |
| bus_wr | input | 1 | CPU write strobe |
| bus_addr | input | ADDR_W | CPU address; MSB selects EEPROM area |
| bus_wdata | input | 8 | CPU write data |
| bus_rdata | output | 8 | Read data or 0xFF blank |
| bus_wait | output | 1 | Access stall during power-down and recovery |
| arr_rd | output | 1 | Read forwarded to array |
| arr_wr | output | 1 | Write forwarded to array |
| arr_addr | output | ADDR_W | Address to array |
| arr_wdata | output | 8 | Write data to array |
| arr_rdata | input | 8 | Array read data |
| pf_wr_start | input | 1 | Program-area write starts |
| ee_page_latch | input | 1 | First EEPROM page-update address latched |
| chip_erase_start | input | 1 | Chip erase starts |
| wr_done | input | 1 | Write finished normally |
| wr_fail | input | 1 | Write finished with error |
| erase_suspend | input | 1 | Erase suspended |
| erase_resume | input | 1 | Suspended erase resumes |
| cfg_wfi_deep | input | 1 | Wait-for-interrupt uses power-down |
| cfg_irq_eow | input | 1 | Interrupt channel takes end-of-write |
| cfg_ee_chip_mode | input | 1 | Chip erase marks EEPROM area busy |
| req_wfi | input | 1 | Wait-for-interrupt request |
| req_halt | input | 1 | Halt or stop request |
| wake | input | 1 | Wake-up event |
| ext_irq | input | 1 | External interrupt pin |
| irq_out | output | 1 | Muxed interrupt channel |
| ee_busy | output | 1 | EEPROM-area busy flag |
| arr_standby | output | 1 | Array in standby |
| arr_powerdown | output | 1 | Array in power-down |
| pf_sect_stat | input | 6 | Program sector status |
| ee_sect_stat | input | 2 | EEPROM sector status |
| otp_stat | input | 1 | Test/OTP area status |
| err_clr | input | 1 | Clear write-error flag |
| status_reg | output | 8 | Error flag and sector status |

## Verification
The hardest chain to reach from the ports starts with a low-power request made while a write is in flight. The request must stay pending until the write ends. Entry into power-down must then happen exactly one edge later. The wake that follows must run the recovery window and then the ready window back to back.

The stimulus reaches this chain in steps. It starts a program-area write and issues a deep wait-for-interrupt request. It holds the write open for several cycles, then completes it. After the wake, it keeps a read asserted and counts edges to find where `bus_wait` falls and where `ee_busy` falls. The sector map is swept over all 512 input combinations on instances of both array sizes.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;

    typedef enum logic [2:0] {
        PW_READY_WAIT,
        PW_ACTIVE,
        PW_ENTRY_PEND,
        PW_STANDBY,
        PW_POWERDOWN,
        PW_RECOVER
    } pwr_state_e;

    typedef enum logic [1:0] {
        WR_IDLE,
        WR_PROG,
        WR_EE,
        WR_SUSP
    } wr_state_e;

    localparam logic [7:0] BLANK_BYTE = 8'hFF;

endpackage

// File: rtl/nvm_write_tracker.sv
module nvm_write_tracker
    import nvm_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pf_wr_start,
    input  logic ee_page_latch,
    input  logic chip_erase_start,
    input  logic cfg_ee_chip_mode,
    input  logic wr_done,
    input  logic wr_fail,
    input  logic erase_suspend,
    input  logic erase_resume,
    output logic pf_active,
    output logic ee_active,
    output logic eow_pulse,
    output logic fail_pulse
);

    wr_state_e state_q, state_d;
    logic      susp_ee_q;
    logic      eow_q;
    logic      busy;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WR_IDLE: begin
                if (ee_page_latch || (chip_erase_start && cfg_ee_chip_mode))
                    state_d = WR_EE;
                else if (pf_wr_start || chip_erase_start)
                    state_d = WR_PROG;
            end
            WR_PROG, WR_EE: begin
                if (wr_done || wr_fail)
                    state_d = WR_IDLE;
                else if (erase_suspend)
                    state_d = WR_SUSP;
            end
            WR_SUSP: begin
                if (erase_resume)
                    state_d = susp_ee_q ? WR_EE : WR_PROG;
            end
            default: state_d = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= WR_IDLE;
            susp_ee_q <= 1'b0;
            eow_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            if (busy && erase_suspend && !(wr_done || wr_fail))
                susp_ee_q <= (state_q == WR_EE);
            eow_q <= busy && wr_done;
        end
    end

    always_comb begin
        busy       = (state_q == WR_PROG) || (state_q == WR_EE);
        pf_active  = (state_q == WR_PROG);
        ee_active  = (state_q == WR_EE);
        eow_pulse  = eow_q;
        fail_pulse = busy && wr_fail;
    end

endmodule

// File: rtl/nvm_pwr_fsm.sv
module nvm_pwr_fsm
    import nvm_seq_pkg::*;
#(
    parameter int unsigned RECOV_CYC = 1000,
    parameter int unsigned READY_CYC = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_wfi,
    input  logic req_halt,
    input  logic wake,
    input  logic cfg_wfi_deep,
    input  logic write_active,
    output logic arr_standby,
    output logic arr_powerdown,
    output logic ready_window,
    output logic access_stall
);

    localparam int unsigned MAX_CYC = (RECOV_CYC > READY_CYC) ? RECOV_CYC : READY_CYC;
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] RECOV_LOAD = CNT_W'(RECOV_CYC - 1);
    localparam logic [CNT_W-1:0] READY_LOAD = CNT_W'(READY_CYC - 1);

    pwr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             deep_q;
    logic             cnt_zero;

    assign cnt_zero = (cnt_q == '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PW_READY_WAIT: if (cnt_zero)             state_d = PW_ACTIVE;
            PW_ACTIVE:     if (req_wfi || req_halt)  state_d = PW_ENTRY_PEND;
            PW_ENTRY_PEND: if (!write_active)        state_d = deep_q ? PW_POWERDOWN : PW_STANDBY;
            PW_STANDBY:    if (wake)                 state_d = PW_ACTIVE;
            PW_POWERDOWN:  if (wake)                 state_d = PW_RECOVER;
            PW_RECOVER:    if (cnt_zero)             state_d = PW_READY_WAIT;
            default:                                 state_d = PW_READY_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PW_READY_WAIT;
            cnt_q   <= READY_LOAD;
            deep_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == PW_ACTIVE && (req_wfi || req_halt))
                deep_q <= req_halt || cfg_wfi_deep;
            if (state_d == PW_RECOVER && state_q != PW_RECOVER)
                cnt_q <= RECOV_LOAD;
            else if (state_d == PW_READY_WAIT && state_q != PW_READY_WAIT)
                cnt_q <= READY_LOAD;
            else if (!cnt_zero)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        arr_standby   = (state_q == PW_STANDBY);
        arr_powerdown = (state_q == PW_POWERDOWN);
        ready_window  = (state_q == PW_READY_WAIT);
        access_stall  = (state_q == PW_POWERDOWN) || (state_q == PW_RECOVER);
    end

endmodule

// File: rtl/nvm_access_gate.sv
module nvm_access_gate
    import nvm_seq_pkg::*;
(
    input  logic       bus_rd,
    input  logic       bus_wr,
    input  logic       is_ee,
    input  logic       ee_busy,
    input  logic       pf_active,
    input  logic       stall,
    input  logic [7:0] arr_rdata,
    output logic [7:0] bus_rdata,
    output logic       bus_wait,
    output logic       arr_rd,
    output logic       arr_wr
);

    logic rd_blank;
    logic wr_drop;

    always_comb begin
        rd_blank  = stall || (is_ee ? ee_busy : pf_active);
        wr_drop   = stall || (is_ee && ee_busy);
        bus_wait  = stall && (bus_rd || bus_wr);
        arr_rd    = bus_rd && !rd_blank;
        arr_wr    = bus_wr && !wr_drop;
        bus_rdata = rd_blank ? BLANK_BYTE : arr_rdata;
    end

endmodule

// File: rtl/nvm_status_reg.sv
module nvm_status_reg #(
    parameter bit LARGE_ARRAY = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fail_pulse,
    input  logic       err_clr,
    input  logic [5:0] pf_sect_stat,
    input  logic [1:0] ee_sect_stat,
    input  logic       otp_stat,
    output logic [7:0] status_reg
);

    logic       err_q;
    logic [3:0] pf_map;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (fail_pulse)
            err_q <= 1'b1;
        else if (err_clr)
            err_q <= 1'b0;
    end

    generate
        if (LARGE_ARRAY) begin : g_large
            assign pf_map = {|pf_sect_stat[5:3], pf_sect_stat[2:0]};
        end else begin : g_small
            logic [1:0] unused_hi;
            assign unused_hi = pf_sect_stat[5:4];
            assign pf_map    = pf_sect_stat[3:0];
        end
    endgenerate

    assign status_reg = {err_q, otp_stat, ee_sect_stat, pf_map};

endmodule

// File: rtl/nvm_busy_pwr_seq.sv
module nvm_busy_pwr_seq
    import nvm_seq_pkg::*;
#(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned CLK_MHZ     = 100,
    parameter int unsigned RECOV_NS    = 10000,
    parameter int unsigned READY_NS    = 10000000,
    parameter bit          LARGE_ARRAY = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              bus_wait,
    output logic              arr_rd,
    output logic              arr_wr,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        arr_wdata,
    input  logic [7:0]        arr_rdata,
    input  logic              pf_wr_start,
    input  logic              ee_page_latch,
    input  logic              chip_erase_start,
    input  logic              wr_done,
    input  logic              wr_fail,
    input  logic              erase_suspend,
    input  logic              erase_resume,
    input  logic              cfg_wfi_deep,
    input  logic              cfg_irq_eow,
    input  logic              cfg_ee_chip_mode,
    input  logic              req_wfi,
    input  logic              req_halt,
    input  logic              wake,
    input  logic              ext_irq,
    output logic              irq_out,
    output logic              ee_busy,
    output logic              arr_standby,
    output logic              arr_powerdown,
    input  logic [5:0]        pf_sect_stat,
    input  logic [1:0]        ee_sect_stat,
    input  logic              otp_stat,
    input  logic              err_clr,
    output logic [7:0]        status_reg
);

    localparam int unsigned RECOV_RAW = (CLK_MHZ * RECOV_NS) / 1000;
    localparam int unsigned READY_RAW = (CLK_MHZ * READY_NS) / 1000;
    localparam int unsigned RECOV_CYC = (RECOV_RAW == 0) ? 1 : RECOV_RAW;
    localparam int unsigned READY_CYC = (READY_RAW == 0) ? 1 : READY_RAW;

    logic pf_active, ee_active, eow_pulse, fail_pulse;
    logic wr_active, ready_window, access_stall;

    nvm_write_tracker u_wr (
        .clk              (clk),
        .rst_n            (rst_n),
        .pf_wr_start      (pf_wr_start),
        .ee_page_latch    (ee_page_latch),
        .chip_erase_start (chip_erase_start),
        .cfg_ee_chip_mode (cfg_ee_chip_mode),
        .wr_done          (wr_done),
        .wr_fail          (wr_fail),
        .erase_suspend    (erase_suspend),
        .erase_resume     (erase_resume),
        .pf_active        (pf_active),
        .ee_active        (ee_active),
        .eow_pulse        (eow_pulse),
        .fail_pulse       (fail_pulse)
    );

    assign wr_active = pf_active || ee_active;

    nvm_pwr_fsm #(
        .RECOV_CYC (RECOV_CYC),
        .READY_CYC (READY_CYC)
    ) u_pwr (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_wfi       (req_wfi),
        .req_halt      (req_halt),
        .wake          (wake),
        .cfg_wfi_deep  (cfg_wfi_deep),
        .write_active  (wr_active),
        .arr_standby   (arr_standby),
        .arr_powerdown (arr_powerdown),
        .ready_window  (ready_window),
        .access_stall  (access_stall)
    );

    assign ee_busy = ee_active || ready_window;

    nvm_access_gate u_gate (
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .is_ee     (bus_addr[ADDR_W-1]),
        .ee_busy   (ee_busy),
        .pf_active (pf_active),
        .stall     (access_stall),
        .arr_rdata (arr_rdata),
        .bus_rdata (bus_rdata),
        .bus_wait  (bus_wait),
        .arr_rd    (arr_rd),
        .arr_wr    (arr_wr)
    );

    assign arr_addr  = bus_addr;
    assign arr_wdata = bus_wdata;
    assign irq_out   = cfg_irq_eow ? eow_pulse : ext_irq;

    nvm_status_reg #(
        .LARGE_ARRAY (LARGE_ARRAY)
    ) u_stat (
        .clk          (clk),
        .rst_n        (rst_n),
        .fail_pulse   (fail_pulse),
        .err_clr      (err_clr),
        .pf_sect_stat (pf_sect_stat),
        .ee_sect_stat (ee_sect_stat),
        .otp_stat     (otp_stat),
        .status_reg   (status_reg)
    );

endmodule

// File: rtl/nvm_seq_checker.sv
module nvm_seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_rd,
    input logic       bus_wr,
    input logic       bus_addr_msb,
    input logic       bus_wait,
    input logic [7:0] bus_rdata,
    input logic       arr_rd,
    input logic       arr_wr,
    input logic       ee_busy,
    input logic       arr_standby,
    input logic       arr_powerdown,
    input logic       eow_pulse,
    input logic       wr_done,
    input logic       wr_active,
    input logic       status_err,
    input logic       err_clr
);

    p_ee_rd_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_busy && bus_rd && bus_addr_msb && !bus_wait) |-> (bus_rdata == 8'hFF && !arr_rd));

    p_ee_wr_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_busy && bus_addr_msb) |-> !arr_wr);

    p_lp_defer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(arr_standby) || $rose(arr_powerdown)) |-> !$past(wr_active));

    p_lp_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(arr_standby && arr_powerdown));

    p_pd_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        arr_powerdown |-> (!arr_rd && !arr_wr && (bus_wait || !(bus_rd || bus_wr))));

    p_eow_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        eow_pulse |-> ($past(wr_done) && $past(wr_active)));

    p_eow_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        eow_pulse |=> !eow_pulse);

    p_err_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (status_err && !err_clr) |=> status_err);

endmodule

bind nvm_busy_pwr_seq nvm_seq_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_rd        (bus_rd),
    .bus_wr        (bus_wr),
    .bus_addr_msb  (bus_addr[ADDR_W-1]),
    .bus_wait      (bus_wait),
    .bus_rdata     (bus_rdata),
    .arr_rd        (arr_rd),
    .arr_wr        (arr_wr),
    .ee_busy       (ee_busy),
    .arr_standby   (arr_standby),
    .arr_powerdown (arr_powerdown),
    .eow_pulse     (eow_pulse),
    .wr_done       (wr_done),
    .wr_active     (wr_active),
    .status_err    (status_reg[7]),
    .err_clr       (err_clr)
);

// File: tb/tb_nvm_busy_pwr_seq.sv
module tb_nvm_busy_pwr_seq;

    localparam int RC = 5;   // recovery cycles: 100 MHz * 50 ns
    localparam int YC = 10;  // ready cycles:    100 MHz * 100 ns

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 0, bus_wr = 0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata, arr_wdata, arr_rdata;
    logic [15:0] arr_addr;
    logic        bus_wait, arr_rd, arr_wr;
    logic        pf_wr_start = 0, ee_page_latch = 0, chip_erase_start = 0;
    logic        wr_done = 0, wr_fail = 0, erase_suspend = 0, erase_resume = 0;
    logic        cfg_wfi_deep = 0, cfg_irq_eow = 0, cfg_ee_chip_mode = 0;
    logic        req_wfi = 0, req_halt = 0, wake = 0, ext_irq = 0, err_clr = 0;
    logic        irq_out, ee_busy, arr_standby, arr_powerdown;
    logic [5:0]  pf_sect_stat = '0;
    logic [1:0]  ee_sect_stat = '0;
    logic        otp_stat = 0;
    logic [7:0]  status_reg;
    logic [7:0]  s_rdata, s_wdata, s_status;
    logic [15:0] s_addr;
    logic        s_wait, s_rd, s_wr, s_irq, s_busy, s_sb, s_pd;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    // behavioural array: data is a function of address
    assign arr_rdata = arr_addr[7:0] ^ 8'h5A;

    nvm_busy_pwr_seq #(.ADDR_W(16), .CLK_MHZ(100), .RECOV_NS(50), .READY_NS(100),
                       .LARGE_ARRAY(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_wait(bus_wait), .arr_rd(arr_rd),
        .arr_wr(arr_wr), .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_rdata(arr_rdata),
        .pf_wr_start(pf_wr_start), .ee_page_latch(ee_page_latch),
        .chip_erase_start(chip_erase_start), .wr_done(wr_done), .wr_fail(wr_fail),
        .erase_suspend(erase_suspend), .erase_resume(erase_resume),
        .cfg_wfi_deep(cfg_wfi_deep), .cfg_irq_eow(cfg_irq_eow),
        .cfg_ee_chip_mode(cfg_ee_chip_mode), .req_wfi(req_wfi), .req_halt(req_halt),
        .wake(wake), .ext_irq(ext_irq), .irq_out(irq_out), .ee_busy(ee_busy),
        .arr_standby(arr_standby), .arr_powerdown(arr_powerdown),
        .pf_sect_stat(pf_sect_stat), .ee_sect_stat(ee_sect_stat), .otp_stat(otp_stat),
        .err_clr(err_clr), .status_reg(status_reg));

    nvm_busy_pwr_seq #(.ADDR_W(16), .CLK_MHZ(100), .RECOV_NS(50), .READY_NS(100),
                       .LARGE_ARRAY(1'b0)) dut_s (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(s_rdata), .bus_wait(s_wait), .arr_rd(s_rd),
        .arr_wr(s_wr), .arr_addr(s_addr), .arr_wdata(s_wdata), .arr_rdata(arr_rdata),
        .pf_wr_start(pf_wr_start), .ee_page_latch(ee_page_latch),
        .chip_erase_start(chip_erase_start), .wr_done(wr_done), .wr_fail(wr_fail),
        .erase_suspend(erase_suspend), .erase_resume(erase_resume),
        .cfg_wfi_deep(cfg_wfi_deep), .cfg_irq_eow(cfg_irq_eow),
        .cfg_ee_chip_mode(cfg_ee_chip_mode), .req_wfi(req_wfi), .req_halt(req_halt),
        .wake(wake), .ext_irq(ext_irq), .irq_out(s_irq), .ee_busy(s_busy),
        .arr_standby(s_sb), .arr_powerdown(s_pd),
        .pf_sect_stat(pf_sect_stat), .ee_sect_stat(ee_sect_stat), .otp_stat(otp_stat),
        .err_clr(err_clr), .status_reg(s_status));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        steps(3);
        #1;
        chk("R1 busy in reset", ee_busy, 1);
        chk("R12 err reset", status_reg[7], 0);
        chk("R7 no low power in reset", {arr_standby, arr_powerdown}, 0);

        // R1: power-up ready window sweep
        @(negedge clk);
        rst_n = 1;
        for (int n = 0; n <= YC; n++) begin
            #1;
            chk("R1 ready window", ee_busy, (n < YC) ? 1 : 0);
            if (n == 2) begin
                bus_rd = 1; bus_addr = 16'h8013; #1;
                chk("R1 ee read blank", bus_rdata, 8'hFF);
                chk("R1 ee read not issued", arr_rd, 0);
                bus_addr = 16'h0013; #1;
                chk("R1 pf read served", bus_rdata, 8'h13 ^ 8'h5A);
                bus_rd = 0; bus_wr = 1; bus_addr = 16'h8020; #1;
                chk("R1 ee write dropped", arr_wr, 0);
                bus_wr = 0;
            end
            step();
        end

        // R13: exhaustive sector map sweep on both sizes
        for (int i = 0; i < 512; i++) begin
            pf_sect_stat = i[5:0]; ee_sect_stat = i[7:6]; otp_stat = i[8];
            #1;
            chk("R13 large map", status_reg[6:0],
                {i[8], i[7:6], (i[5] | i[4] | i[3]), i[2:0]});
            chk("R13 small map", s_status[6:0], {i[8], i[7:6], i[3:0]});
        end
        step();

        // R10: external pin path
        cfg_irq_eow = 0;
        for (int v = 0; v < 2; v++) begin
            ext_irq = v[0]; #1;
            chk("R10 pin to irq", irq_out, v[0]);
        end
        ext_irq = 0;
        cfg_irq_eow = 1;

        // R2 page latch
        ee_page_latch = 1; step(); ee_page_latch = 0; #1;
        chk("R2 page latch sets busy", ee_busy, 1);
        bus_rd = 1; bus_addr = 16'h8005; #1;
        chk("R4 ee read blank", bus_rdata, 8'hFF);
        chk("R4 ee read not issued", arr_rd, 0);
        bus_addr = 16'h0005; #1;
        chk("R4 pf read served", bus_rdata, 8'h05 ^ 8'h5A);
        bus_rd = 0; bus_wr = 1; bus_addr = 16'h8005; #1;
        chk("R4 ee write dropped", arr_wr, 0);
        bus_wr = 0;
        // R11 done -> pulse
        wr_done = 1; step(); wr_done = 0; #1;
        chk("R3 done clears busy", ee_busy, 0);
        chk("R11 eow pulse", irq_out, 1);
        step(); #1;
        chk("R11 pulse one cycle", irq_out, 0);
        bus_wr = 1; bus_addr = 16'h8005; #1;
        chk("R4 ee write passes when idle", arr_wr, 1);
        bus_wr = 0;

        // R2/R5 chip erase with mode 0 -> program area busy
        cfg_ee_chip_mode = 0;
        chip_erase_start = 1; step(); chip_erase_start = 0; #1;
        chk("R2 chip erase mode0 ee idle", ee_busy, 0);
        bus_rd = 1; bus_addr = 16'h0040; #1;
        chk("R5 pf read blank", bus_rdata, 8'hFF);
        bus_addr = 16'h8040; #1;
        chk("R5 ee read served", bus_rdata, 8'h40 ^ 8'h5A);
        bus_rd = 0;
        // R3 suspend / resume on program area
        erase_suspend = 1; step(); erase_suspend = 0; #1;
        chk("R11 no pulse on suspend", irq_out, 0);
        bus_rd = 1; bus_addr = 16'h0040; #1;
        chk("R3 suspend releases pf", bus_rdata, 8'h40 ^ 8'h5A);
        bus_rd = 0;
        erase_resume = 1; step(); erase_resume = 0;
        bus_rd = 1; #1;
        chk("R3 resume re-blocks pf", bus_rdata, 8'hFF);
        bus_rd = 0;
        wr_done = 1; step(); wr_done = 0; step();

        // R2 chip erase mode 1, R3 suspend on ee
        cfg_ee_chip_mode = 1;
        chip_erase_start = 1; step(); chip_erase_start = 0; #1;
        chk("R2 chip erase mode1 ee busy", ee_busy, 1);
        erase_suspend = 1; step(); erase_suspend = 0; #1;
        chk("R3 suspend clears ee busy", ee_busy, 0);
        chk("R11 no pulse on ee suspend", irq_out, 0);
        erase_resume = 1; step(); erase_resume = 0; #1;
        chk("R3 resume sets ee busy", ee_busy, 1);
        // R12 fail sets error, no pulse
        wr_fail = 1; step(); wr_fail = 0; #1;
        chk("R3 fail clears busy", ee_busy, 0);
        chk("R12 error set", status_reg[7], 1);
        chk("R11 no pulse on fail", irq_out, 0);
        steps(3); #1;
        chk("R12 error sticky", status_reg[7], 1);
        err_clr = 1; step(); err_clr = 0; #1;
        chk("R12 error cleared", status_reg[7], 0);
        // set wins over clear
        ee_page_latch = 1; step(); ee_page_latch = 0;
        wr_fail = 1; err_clr = 1; step(); wr_fail = 0; err_clr = 0; #1;
        chk("R12 set beats clear", status_reg[7], 1);
        err_clr = 1; step(); err_clr = 0;

        // R7 wfi to standby, no write
        cfg_wfi_deep = 0;
        req_wfi = 1; step(); req_wfi = 0; #1;
        chk("R7 standby not yet", arr_standby, 0);
        step(); #1;
        chk("R7 wfi standby", arr_standby, 1);
        chk("R7 not powerdown", arr_powerdown, 0);
        bus_rd = 1; bus_addr = 16'h0077; #1;
        chk("R8 standby no wait", bus_wait, 0);
        chk("R8 standby read served", bus_rdata, 8'h77 ^ 8'h5A);
        bus_rd = 0;
        wake = 1; step(); wake = 0; #1;
        chk("R8 wake leaves standby", arr_standby, 0);
        chk("R8 no ready window after standby", ee_busy, 0);

        // R6 deferred deep entry behind a program write
        cfg_wfi_deep = 1;
        pf_wr_start = 1; step(); pf_wr_start = 0;
        req_wfi = 1; step(); req_wfi = 0;
        for (int k = 0; k < 4; k++) begin
            #1; chk("R6 held while writing", arr_powerdown, 0); step();
        end
        wr_done = 1; step(); wr_done = 0; #1;
        chk("R6 not on ending edge", arr_powerdown, 0);
        step(); #1;
        chk("R6 entry after write", arr_powerdown, 1);
        chk("R7 deep wfi powerdown", arr_standby, 0);

        // R9 recovery then ready window, read held
        bus_rd = 1; bus_addr = 16'h0011; #1;
        chk("R9 powerdown stalls", bus_wait, 1);
        wake = 1; step(); wake = 0;
        for (int n = 1; n <= RC + 1 + YC; n++) begin
            #1;
            chk("R9 recovery wait", bus_wait, (n <= RC) ? 1 : 0);
            chk("R9 ready window busy", ee_busy, (n > RC && n <= RC + YC) ? 1 : 0);
            if (n == RC + 3) begin
                req_wfi = 1; // R14: ignored during ready window
                step();
                req_wfi = 0;
            end else begin
                step();
            end
        end
        bus_rd = 0;
        steps(3); #1;
        chk("R14 request ignored", {arr_standby, arr_powerdown}, 0);

        // R7 halt always deep even with cfg 0
        cfg_wfi_deep = 0;
        req_halt = 1; step(); req_halt = 0; step(); #1;
        chk("R7 halt powerdown", arr_powerdown, 1);
        chk("R7 halt not standby", arr_standby, 0);

        finish_run();
    end

endmodule